// File: doc/BRIEF.md
# Gated muxed module clock generator

This block derives one output clock from a small set of source clocks. A single 32-bit control word selects the source. It sets a power-of-two pre-divider and a linear divide-by-(m+1), and it gates the result. The output frequency is the selected source frequency divided by 2^p and then by (m+1). The divider never emits a shortened pulse. New divide values and a new source take effect only at the point where the output would rise. A disabled output first finishes its current period and then rests low.

The source clocks are level inputs oversampled by the core clock `clk`. Each source level must hold for at least two `clk` cycles. The divider counts source half-periods, rising and falling edges alike. Each output phase, high and low, lasts exactly N half-periods of the source, where N = (m+1)·2^p. The duty cycle is therefore 50% for odd ratios as well. The register port is a plain write strobe with data and a continuous read-back. It accepts a write in every cycle and has no back-pressure. The source and output clocks carry no handshake.

Parameter `SEL_W` gives a narrow variant with 4 sources (2 select bits) or a wide variant with 16 sources (4 select bits). Parameter `ALWAYS_ON` gives a variant for clocks that must never stop. That variant runs whatever the enable bit holds.

Top module: `modclk_gen`

## Requirements
- R1: `rd_data` returns every one of the 32 bits last written through `wr_en`/`wr_data`, including bits with no function, from the cycle after the write.
- R2: The linear field m is at bits [3:0] and the shift field p is at bits [17:16]. With N = (m+1)·2^p, every output high phase and every output low phase lasts exactly N half-periods (edges) of the active source. Odd N gives the same 50% duty.
- R3: The source select field starts at bit 24 and is `SEL_W` bits wide (2 or 4). The value s selects `src_clk[s]`.
- R4: Bit 31 is the enable (1 = run). When it is 0 in the non-critical variant, the output completes its current period and is then held low with no further transitions.
- R5: With `ALWAYS_ON` = 1 the output runs at the configured ratio and source whatever bit 31 holds, also straight after reset.
- R6: A write that changes m or p takes effect only at a period boundary, where the output would go from low to high. Every output phase after such a write lasts either the old N or the new N.
- R7: A write that changes the source lets the current period finish. The output then stays low until a rising edge of the new source. The output changes only in the cycle after an edge of the active source.
- R8: After reset the register reads 0 (disabled, source 0, divide by 1) and, in the non-critical variant, the output is low.
- R9: The output rises only in the cycle after a rising edge of the active source, so output rising edges line up with source rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the sources and clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word |
| src_clk | input | 2^SEL_W | Source clock levels |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
The hardest situation to reach is a reconfiguration that lands in the middle of a running period. A change of m or p must then wait for the boundary, and a change of source must stretch the low phase rather than cut it. The bench first lets a known ratio settle on a source. It then writes a new ratio after a random number of cycles, so the write falls at different points of the high and low phases. It measures every following phase in edges of the source and accepts only the old or the new N. The source-switch path is reached the same way, by changing only the select field on a running output. The measurement then follows the new source.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
  localparam int CFG_W   = 32;
  localparam int M_LSB   = 0;
  localparam int M_W     = 4;
  localparam int P_LSB   = 16;
  localparam int P_W     = 2;
  localparam int SEL_LSB = 24;
  localparam int EN_BIT  = 31;
  // widest total ratio: (2^M_W) << (2^P_W - 1)
  localparam int N_W     = M_W + (1 << P_W);

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
  } div_set_t;

  function automatic logic [N_W-1:0] total_div(div_set_t d);
    logic [N_W-1:0] base;
    base = N_W'(d.m) + N_W'(1);
    return base << d.p;
  endfunction
endpackage

// File: rtl/modclk_cfg_reg.sv
module modclk_cfg_reg
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output div_set_t         div_req,
  output logic [SEL_W-1:0] sel_req,
  output logic             en_req
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

  assign rd_data   = word_q;
  assign div_req.m = word_q[M_LSB +: M_W];
  assign div_req.p = word_q[P_LSB +: P_W];
  assign sel_req   = word_q[SEL_LSB +: SEL_W];

  generate
    if (ALWAYS_ON) begin : g_crit
      assign en_req = 1'b1;
    end else begin : g_gated
      assign en_req = word_q[EN_BIT];
    end
  endgenerate

  // R1: the stored word is visible one cycle after the write
  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));
endmodule

// File: rtl/modclk_src_edge.sv
module modclk_src_edge #(
  parameter int SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<SEL_W)-1:0]   src_clk,
  input  logic [SEL_W-1:0]        sel,
  output logic                    any_edge,
  output logic                    rise_edge
);
  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise_v;
  logic [NSRC-1:0] fall_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_clk;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign rise_v[i] = src_clk[i] & ~prev_q[i];
      assign fall_v[i] = ~src_clk[i] & prev_q[i];
    end
  endgenerate

  assign rise_edge = rise_v[sel];
  assign any_edge  = rise_v[sel] | fall_v[sel];
endmodule

// File: rtl/modclk_div_core.sv
module modclk_div_core
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  div_set_t         div_req,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             en_req,
  input  logic             any_edge,
  input  logic             rise_edge,
  output logic [SEL_W-1:0] sel_act,
  output logic             clk_out
);
  div_set_t       dset_act;
  logic           running;
  logic           out_q;
  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] n_last;
  logic           same_src;

  assign n_last   = total_div(dset_act) - N_W'(1);
  assign same_src = (sel_req == sel_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      out_q    <= 1'b0;
      cnt_q    <= '0;
      dset_act <= '0;
      sel_act  <= '0;
    end else if (!running) begin
      // parked low: track the request, start on a rising source edge
      dset_act <= div_req;
      sel_act  <= sel_req;
      if (en_req && rise_edge && same_src) begin
        running <= 1'b1;
        out_q   <= 1'b1;
        cnt_q   <= '0;
      end
    end else if (any_edge) begin
      if (cnt_q == n_last) begin
        cnt_q <= '0;
        if (out_q) begin
          out_q <= 1'b0;
        end else begin
          // period boundary: output is low, safe to retune
          dset_act <= div_req;
          if (en_req && same_src) out_q   <= 1'b1;
          else                    running <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + N_W'(1);
      end
    end
  end

  assign clk_out = out_q;

  // R2: the phase counter stays inside the active ratio
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q <= n_last));
  // R6: active divide settings only change where the output was low
  assert_retune_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dset_act) |-> !$past(out_q));
  // R7: output moves only after an edge of the active source
  assert_move_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(any_edge));
  // R9: output rises only after a rising source edge
  assert_rise_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(rise_edge));
  // R4: a new high phase needs the enable
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(en_req));
endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  input  logic [(1<<SEL_W)-1:0] src_clk,
  output logic                  clk_out
);
  div_set_t         div_req;
  logic [SEL_W-1:0] sel_req;
  logic [SEL_W-1:0] sel_act;
  logic             en_req;
  logic             any_edge;
  logic             rise_edge;

  modclk_cfg_reg #(.SEL_W(SEL_W), .ALWAYS_ON(ALWAYS_ON)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .div_req (div_req),
    .sel_req (sel_req),
    .en_req  (en_req)
  );

  modclk_src_edge #(.SEL_W(SEL_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_clk   (src_clk),
    .sel       (sel_act),
    .any_edge  (any_edge),
    .rise_edge (rise_edge)
  );

  modclk_div_core #(.SEL_W(SEL_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_req   (div_req),
    .sel_req   (sel_req),
    .en_req    (en_req),
    .any_edge  (any_edge),
    .rise_edge (rise_edge),
    .sel_act   (sel_act),
    .clk_out   (clk_out)
  );
endmodule

// File: tb/modclk_gen_tb_top.sv
`timescale 1ns/1ps
module modclk_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wa_en = 1'b0, wb_en = 1'b0;
  logic [31:0] wa_data = '0, wb_data = '0;
  logic [31:0] rda, rdb;
  logic        out_a, out_b;
  logic [15:0] src_q = '0;

  modclk_gen #(.SEL_W(2), .ALWAYS_ON(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wa_en), .wr_data(wa_data),
    .rd_data(rda), .src_clk(src_q[3:0]), .clk_out(out_a));

  modclk_gen #(.SEL_W(4), .ALWAYS_ON(1'b1)) dut_crit_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wb_en), .wr_data(wb_data),
    .rd_data(rdb), .src_clk(src_q), .clk_out(out_b));

  int checks = 0, errs = 0;
  bit done = 1'b0;
  int hc [16];
  int ed_cnt [2], ph_cnt [2], ph_len [2], mon_sel [2];
  logic ph_lvl [2], ph_src [2], last_o [2];

  function automatic int half_of(int i);
    return 2 + (i % 7);
  endfunction
  function automatic int exp_n(int m, int p);
    return (m + 1) << p;
  endfunction
  function automatic logic [31:0] mkcfg(logic [31:0] rnd, int m, int p, int s, bit en, int sw);
    logic [31:0] w;
    w = rnd;
    w[3:0] = m[3:0];
    w[17:16] = p[1:0];
    if (sw == 2) w[25:24] = s[1:0]; else w[27:24] = s[3:0];
    w[31] = en;
    return w;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) hc[i] = 0;
    for (int d = 0; d < 2; d++) begin
      ed_cnt[d] = 0; ph_cnt[d] = 0; ph_len[d] = 0; mon_sel[d] = 0;
      ph_lvl[d] = 0; ph_src[d] = 0; last_o[d] = 0;
    end
  end

  // phase monitor, then source generation, all at the falling clock edge
  always @(negedge clk) begin
    logic [15:0] tog;
    for (int d = 0; d < 2; d++) begin
      logic o;
      o = (d == 0) ? out_a : out_b;
      if (o !== last_o[d]) begin
        ph_len[d] = ed_cnt[d];
        ph_lvl[d] = o;
        ph_src[d] = src_q[mon_sel[d]];
        ph_cnt[d] = ph_cnt[d] + 1;
        ed_cnt[d] = 0;
        last_o[d] = o;
      end
    end
    tog = '0;
    for (int i = 0; i < 16; i++) begin
      if (hc[i] == half_of(i) - 1) begin
        hc[i] = 0; src_q[i] = ~src_q[i]; tog[i] = 1'b1;
      end else hc[i] = hc[i] + 1;
    end
    for (int d = 0; d < 2; d++)
      if (tog[mon_sel[d]]) ed_cnt[d] = ed_cnt[d] + 1;
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(int d, logic [31:0] v);
    @(negedge clk);
    if (d == 0) begin wa_en = 1'b1; wa_data = v; end
    else        begin wb_en = 1'b1; wb_data = v; end
    @(negedge clk);
    wa_en = 1'b0; wb_en = 1'b0;
  endtask

  task automatic wait_phase(int d, string req);
    int start, t;
    start = ph_cnt[d];
    t = 0;
    while (ph_cnt[d] == start && t < 20000) begin @(posedge clk); t++; end
    if (t >= 20000) check(1'b0, req, t, 0);
  endtask

  task automatic measure(int d, int s, int n, int nflush, int nmeas, string req);
    mon_sel[d] = s;
    for (int k = 0; k < nflush; k++) wait_phase(d, req);
    for (int k = 0; k < nmeas; k++) begin
      wait_phase(d, req);
      check(ph_len[d] == n, req, ph_len[d], n);
      if (ph_lvl[d] == 1'b1) check(ph_src[d] == 1'b1, "R9 rise aligned", ph_src[d], 1);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: reset state
    check(rda == 32'h0, "R8 reset word", rda, 0);
    check(rdb == 32'h0, "R8 reset word wide", rdb, 0);
    begin
      int hi = 0;
      repeat (60) begin @(negedge clk); if (out_a) hi++; end
      check(hi == 0, "R8 output low after reset", hi, 0);
    end
    // R5: critical variant runs from reset on source 0, divide by 1
    measure(1, 0, 1, 3, 4, "R5 critical runs after reset");

    // R1: readback of every bit
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = $urandom;
      wr(1, w);
      check(rdb == w, "R1 readback", rdb, w);
    end

    // R2 directed: odd ratios, N=3 and N=15, 50% duty in half-periods
    wr(0, mkcfg(32'h0, 2, 0, 1, 1'b1, 2));
    measure(0, 1, 3, 3, 4, "R2 odd N=3");
    wr(0, mkcfg(32'h0, 14, 0, 2, 1'b1, 2));
    measure(0, 2, 15, 3, 4, "R2 odd N=15");
    wr(0, mkcfg(32'h0, 15, 3, 0, 1'b1, 2));
    measure(0, 0, 128, 3, 2, "R2 max N=128");

    // R2/R3 random configurations, unused bits random
    for (int k = 0; k < 12; k++) begin
      int m, p, s;
      logic [31:0] w;
      m = $urandom % 16; p = $urandom % 4; s = $urandom % 4;
      w = mkcfg($urandom, m, p, s, 1'b1, 2);
      wr(0, w);
      check(rda == w, "R1 readback random", rda, w);
      measure(0, s, exp_n(m, p), 3, 4, "R2 R3 random ratio/source");
    end

    // R6: retune mid-period on the same source
    for (int k = 0; k < 4; k++) begin
      int m1, m2, p1, p2, s, n1, n2;
      m1 = $urandom % 16; p1 = $urandom % 2; m2 = $urandom % 16; p2 = $urandom % 2;
      s = $urandom % 4;
      n1 = exp_n(m1, p1); n2 = exp_n(m2, p2);
      wr(0, mkcfg(32'h0, m1, p1, s, 1'b1, 2));
      measure(0, s, n1, 3, 2, "R6 settle");
      repeat ($urandom % 200) @(negedge clk);
      wr(0, mkcfg(32'h0, m2, p2, s, 1'b1, 2));
      for (int j = 0; j < 5; j++) begin
        wait_phase(0, "R6 retune");
        check(ph_len[0] == n1 || ph_len[0] == n2, "R6 no short phase", ph_len[0], n2);
      end
      measure(0, s, n2, 0, 2, "R6 new ratio applied");
    end

    // R7: switch source on a running output
    wr(0, mkcfg(32'h0, 3, 1, 0, 1'b1, 2));
    measure(0, 0, 8, 3, 2, "R7 before switch");
    wr(0, mkcfg(32'h0, 3, 1, 3, 1'b1, 2));
    measure(0, 3, 8, 3, 4, "R7 after switch");

    // R4: disable lets the period finish, then holds low
    wr(0, mkcfg(32'h0, 2, 1, 1, 1'b1, 2));
    measure(0, 1, 6, 3, 2, "R4 running");
    wr(0, mkcfg(32'h0, 2, 1, 1, 1'b0, 2));
    repeat (400) @(negedge clk);
    begin
      int hi = 0, c0;
      c0 = ph_cnt[0];
      repeat (1500) begin @(negedge clk); if (out_a) hi++; end
      check(hi == 0, "R4 held low when disabled", hi, 0);
      check(ph_cnt[0] == c0, "R4 no transitions when disabled", ph_cnt[0] - c0, 0);
    end
    wr(0, mkcfg(32'h0, 2, 1, 1, 1'b1, 2));
    measure(0, 1, 6, 2, 4, "R4 re-enabled");

    // R3/R5: wide select on the critical variant with the enable bit clear
    wr(1, mkcfg($urandom, 3, 1, 9, 1'b0, 4));
    measure(1, 9, 8, 3, 4, "R3 R5 wide select, enable clear");
    wr(1, mkcfg(32'h0, 4, 0, 14, 1'b0, 4));
    measure(1, 14, 5, 3, 4, "R3 R5 wide select 14");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule